// File: doc/BRIEF.md
# Dual-Word Masked Interrupt Controller

This block gathers 64 interrupt sources and presents them to software as two 32-bit register words, a high word and a low word. Each word has an enable mask, a pending register and an edge-select register. Every source is first passed through a synchronizer. An edge-selected source latches its pending bit on a falling edge. A level source has a pending bit that tracks its input. A single request output tells the CPU that some pending source is also enabled. A read-only vector register names the most urgent of those sources.

Interrupt numbers do not map to bit positions by arithmetic. A fixed, irregular placement puts each number in one of the two words at one bit. Bit positions are counted big-endian, so position b is register value bit 31-b. Priority is fixed: the lowest-numbered active source wins. The vector carries that number in bits 31 to 26.

The register port is a plain single-cycle interface. A write takes effect at the clock edge on which `cfg_we` is high. Read data is combinational from the address. The port has no back-pressure and no handshake, because every access completes in one cycle.

Top module: `irq_dualword_ctrl`

## Requirements
- R1: After reset, every mask, pending and edge-select word reads zero, `irq_req` is low and the vector reads zero.
- R2: Number n sits at big-endian position b, with register value bit 31-b, in the word shown here (word L is the low word, word H is the high word):
  - n=0 is at L/31.
  - n=1..15 is at L/n+15.
  - n=16 is at H/29 and n=17 is at H/30.
  - n=18..30 is at H/n-2 and n=31 is at H/31.
  - n=32..47 is at L/n-32.
  - n=48..63 is at H/63-n.
- R3: A mask bit of 1 enables its source and a mask bit of 0 disables it. A written mask word reads back unchanged.
- R4: A qualifying event sets the pending bit whether or not the source is masked. `irq_req` is high only while at least one pending bit is also enabled.
- R5: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. Writing all ones clears every edge-latched bit in the word.
- R6: The vector word holds, in bits 31..26, the lowest-numbered source that is both pending and enabled. All other bits are zero. When no source is active the whole word is zero.
- R7: With its edge-select bit set to 1, a source latches pending on a high-to-low transition. A rising edge and a steady level do nothing. The bit stays set after the input returns high.
- R8: With its edge-select bit at 0, a source is level-sensitive and active high. Its pending bit follows the synchronized input, and a clearing write has no effect while the input stays high.
- R9: If a clearing write and a new falling edge land in the same cycle, the pending bit ends up set.
- R10: With the default two synchronizer stages, an input change shows in the pending register after the third rising clock edge following the change, and not after the second.
- R11: The address map is as follows:
  - 0 is the high mask word and 1 is the low mask word.
  - 2 is the high pending word and 3 is the low pending word.
  - 4 is the high edge-select word and 5 is the low edge-select word.
  - 6 is the vector word.
  - Writes to 6 and 7 change nothing, and reads of 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 64 | Raw interrupt inputs, bit n is source number n |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| irq_req | output | 1 | Request to the CPU |

## Verification
The hardest case to reach from the ports is a clearing write that meets a new falling edge in the same cycle. The edge becomes visible only after the synchronizer stages, so it cannot be seen directly. The stimulus drops the input at a known falling clock edge and counts two rising edges. It then drives the clearing write in exactly the cycle whose closing edge latches the event, so the two actions collide. A separate scenario samples the pending bit one edge early and one edge on time to pin the synchronizer latency.

// File: rtl/irq_dw_pkg.sv
package irq_dw_pkg;
  localparam int unsigned NSRC = 64;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 3;
  localparam int unsigned NUMW = $clog2(NSRC);
  localparam int unsigned VSH  = DW - NUMW;

  typedef enum logic [AW-1:0] {
    A_MASK_HI = 3'd0,
    A_MASK_LO = 3'd1,
    A_PEND_HI = 3'd2,
    A_PEND_LO = 3'd3,
    A_EDGE_HI = 3'd4,
    A_EDGE_LO = 3'd5,
    A_VEC     = 3'd6
  } reg_addr_e;

  // word select: 0 = high word, 1 = low word
  function automatic int unsigned src_word(input int unsigned n);
    if (n < 16 || (n >= 32 && n < 48)) return 1;
    return 0;
  endfunction

  // little-endian value bit inside the word (31 - big-endian position)
  function automatic int unsigned src_vbit(input int unsigned n);
    if (n == 0)  return 0;
    if (n < 16)  return 16 - n;
    if (n == 16) return 2;
    if (n == 17) return 1;
    if (n < 31)  return 33 - n;
    if (n == 31) return 0;
    if (n < 48)  return 63 - n;
    return n - 32;
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  input  logic edge_mode,
  input  logic clr,
  output logic pend,
  output logic fall,
  output logic lvl
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         prev_q;
  logic         pend_q;
  logic         pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], src_in};
      prev_q <= sync_q[MSB];
      pend_q <= pend_d;
    end
  end

  assign lvl  = sync_q[MSB];
  assign fall = edge_mode & prev_q & ~lvl;

  always_comb begin
    if (edge_mode) pend_d = fall | (pend_q & ~clr);
    else           pend_d = lvl;
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  act,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_dualword_ctrl.sv
module irq_dualword_ctrl
  import irq_dw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  output logic            irq_req
);
  logic [NSRC-1:0]    mask_q, edge_q, pend, fall, lvl, clr, active;
  logic [1:0][DW-1:0] mask_wd, pend_wd, edge_wd;
  logic [1:0]         wr_mask, wr_pend, wr_edge;
  logic               enc_any;
  logic [NUMW-1:0]    enc_idx;
  logic [DW-1:0]      vec_word;

  // per-word write strobes (index 0 = high, 1 = low)
  for (genvar w = 0; w < 2; w++) begin : g_wdec
    assign wr_mask[w] = cfg_we && (cfg_addr == AW'(int'(A_MASK_HI) + w));
    assign wr_pend[w] = cfg_we && (cfg_addr == AW'(int'(A_PEND_HI) + w));
    assign wr_edge[w] = cfg_we && (cfg_addr == AW'(int'(A_EDGE_HI) + w));
  end

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    localparam int unsigned W = src_word(n);
    localparam int unsigned V = src_vbit(n);
    logic m_q, e_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_q <= 1'b0;
        e_q <= 1'b0;
      end else begin
        if (wr_mask[W]) m_q <= cfg_wdata[V];
        if (wr_edge[W]) e_q <= cfg_wdata[V];
      end
    end

    assign mask_q[n] = m_q;
    assign edge_q[n] = e_q;
    assign clr[n]    = wr_pend[W] & cfg_wdata[V];

    irq_src_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_in    (src_in[n]),
      .edge_mode (e_q),
      .clr       (clr[n]),
      .pend      (pend[n]),
      .fall      (fall[n]),
      .lvl       (lvl[n])
    );

    assign mask_wd[W][V] = m_q;
    assign edge_wd[W][V] = e_q;
    assign pend_wd[W][V] = pend[n];
  end

  assign active  = pend & mask_q;
  assign irq_req = |active;

  irq_prio_enc #(.N(NSRC), .IW(NUMW)) u_enc (
    .act (active),
    .any (enc_any),
    .idx (enc_idx)
  );

  assign vec_word = enc_any ? {enc_idx, {VSH{1'b0}}} : '0;

  always_comb begin
    case (cfg_addr)
      A_MASK_HI: cfg_rdata = mask_wd[0];
      A_MASK_LO: cfg_rdata = mask_wd[1];
      A_PEND_HI: cfg_rdata = pend_wd[0];
      A_PEND_LO: cfg_rdata = pend_wd[1];
      A_EDGE_HI: cfg_rdata = edge_wd[0];
      A_EDGE_LO: cfg_rdata = edge_wd[1];
      A_VEC:     cfg_rdata = vec_word;
      default:   cfg_rdata = '0;
    endcase
  end
endmodule

module irq_dualword_chk
  import irq_dw_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            irq_req,
  input logic [DW-1:0]   vec_word,
  input logic [NSRC-1:0] active,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] edge_sel,
  input logic [NSRC-1:0] fall,
  input logic [NSRC-1:0] lvl,
  input logic [NSRC-1:0] clr
);
  logic [NUMW-1:0] vnum;
  assign vnum = vec_word[DW-1:VSH];

  // R6: idle request means a zero vector
  a_r6_vec_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (vec_word == '0));
  // R6: reported number is itself active
  a_r6_vec_is_active: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> active[vnum]);
  // R6: nothing lower-numbered is active
  a_r6_vec_is_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((active & ((64'd1 << vnum) - 64'd1)) == '0));

  for (genvar n = 0; n < NSRC; n++) begin : g_chk
    // R7: an edge-latched bit holds until cleared
    a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[n] && pend[n] && !clr[n]) |=> pend[n]);
    // R9: a new edge beats a same-cycle clear
    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      fall[n] |=> pend[n]);
    // R8: an active level cannot be cleared
    a_r8_level_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_sel[n] && lvl[n]) |=> pend[n]);
  end
endmodule

bind irq_dualword_ctrl irq_dualword_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_req  (irq_req),
  .vec_word (vec_word),
  .active   (active),
  .pend     (pend),
  .edge_sel (edge_q),
  .fall     (fall),
  .lvl      (lvl),
  .clr      (clr)
);

// File: tb/irq_dualword_ctrl_bench.sv
`timescale 1ns/1ps
module irq_dualword_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_in = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  irq_dualword_ctrl u_irq_dualword_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_req(irq_req)
  );

  // reference placement from R2: w 0 = high word, 1 = low word; returns value bit
  function automatic void ref_loc(input int n, output int w, output int v);
    int b;
    if (n == 0)       begin w = 1; b = 31;     end
    else if (n < 16)  begin w = 1; b = n + 15; end
    else if (n == 16) begin w = 0; b = 29;     end
    else if (n == 17) begin w = 0; b = 30;     end
    else if (n < 31)  begin w = 0; b = n - 2;  end
    else if (n == 31) begin w = 0; b = 31;     end
    else if (n < 48)  begin w = 1; b = n - 32; end
    else              begin w = 0; b = 63 - n; end
    v = 31 - b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    cfg_addr = 3'(addr); cfg_wdata = data; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    cfg_addr = 3'(addr);
    #1 data = cfg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 7; a++) begin
      rd(a, d);
      check("R1 reset register", d, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq_req}, 32'h0);
  endtask

  task automatic t_map();
    int list [11] = '{0, 5, 15, 16, 17, 20, 31, 32, 40, 48, 63};
    logic [31:0] d;
    foreach (list[i]) begin
      int n, w, v;
      n = list[i];
      ref_loc(n, w, v);
      @(negedge clk); src_in[n] = 1'b1;
      settle();
      rd(2 + w, d); check($sformatf("R2 pending place n=%0d", n), d, 32'd1 << v);
      rd(3 - w, d); check($sformatf("R2 other word n=%0d", n), d, 32'h0);
      check($sformatf("R4 masked no irq n=%0d", n), {31'b0, irq_req}, 32'h0);
      wr(w, 32'd1 << v);
      rd(w, d); check($sformatf("R3 mask readback n=%0d", n), d, 32'd1 << v);
      check($sformatf("R4 irq when enabled n=%0d", n), {31'b0, irq_req}, 32'h1);
      rd(6, d); check($sformatf("R6 vector n=%0d", n), d, 32'(n) << 26);
      @(negedge clk); src_in[n] = 1'b0;
      settle();
      check($sformatf("R8 level drop irq n=%0d", n), {31'b0, irq_req}, 32'h0);
      rd(6, d); check($sformatf("R6 idle vector n=%0d", n), d, 32'h0);
      wr(w, 32'h0);
    end
  endtask

  task automatic t_priority();
    logic [31:0] d;
    int w, v;
    @(negedge clk); src_in[40] = 1'b1; src_in[3] = 1'b1; src_in[17] = 1'b1;
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
    settle();
    rd(6, d); check("R6 lowest of 3,17,40", d, 32'd3 << 26);
    ref_loc(3, w, v);
    wr(1, ~(32'd1 << v));
    rd(6, d); check("R6 lowest after masking 3", d, 32'd17 << 26);
    wr(0, 32'h0);
    rd(6, d); check("R6 lowest after masking high word", d, 32'd40 << 26);
    @(negedge clk); src_in = '0;
    wr(1, 32'h0);
    settle();
  endtask

  task automatic t_edge_w1c();
    logic [31:0] d;
    int wa, va, wb, vb;
    ref_loc(20, wa, va);
    ref_loc(50, wb, vb);
    wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF);
    @(negedge clk); src_in[20] = 1'b1; src_in[50] = 1'b1;
    settle();
    rd(2, d); check("R7 rise gives nothing", d, 32'h0);
    @(negedge clk); src_in[20] = 1'b0; src_in[50] = 1'b0;
    settle();
    rd(2, d); check("R7 falls latched", d, (32'd1 << va) | (32'd1 << vb));
    @(negedge clk); src_in[20] = 1'b1; src_in[50] = 1'b1;
    settle();
    rd(2, d); check("R7 held after return high", d, (32'd1 << va) | (32'd1 << vb));
    wr(2, 32'h0);
    rd(2, d); check("R5 zero write no effect", d, (32'd1 << va) | (32'd1 << vb));
    wr(2, 32'd1 << va);
    rd(2, d); check("R5 single bit clear", d, 32'd1 << vb);
    wr(2, 32'hFFFF_FFFF);
    rd(2, d); check("R5 all-ones clear", d, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    int w, v;
    ref_loc(20, w, v);
    @(negedge clk); cfg_addr = 3'd2; src_in[20] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R10 not after second edge", cfg_rdata, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R10 set after third edge", cfg_rdata, 32'd1 << v);
    wr(2, 32'hFFFF_FFFF);
    @(negedge clk); src_in[20] = 1'b1;
    settle();
  endtask

  task automatic t_collision();
    logic [31:0] d;
    int w, v;
    ref_loc(20, w, v);
    rd(2, d); check("R9 precondition clear", d, 32'h0);
    @(negedge clk); src_in[20] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); cfg_addr = 3'd2; cfg_wdata = 32'd1 << v; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0; cfg_wdata = '0;
    rd(2, d); check("R9 edge beats clear", d, 32'd1 << v);
    wr(2, 32'd1 << v);
    rd(2, d); check("R9 later clear works", d, 32'h0);
    @(negedge clk); src_in[20] = 1'b1;
    wr(4, 32'h0); wr(5, 32'h0);
    @(negedge clk); src_in = '0;
    settle();
  endtask

  task automatic t_level_noclear();
    logic [31:0] d;
    int w, v;
    ref_loc(5, w, v);
    @(negedge clk); src_in[5] = 1'b1;
    settle();
    wr(3, 32'hFFFF_FFFF);
    rd(3, d); check("R8 level not clearable", d, 32'd1 << v);
    @(negedge clk); src_in[5] = 1'b0;
    settle();
    rd(3, d); check("R8 level follows low", d, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
    rd(7, d); check("R11 unused reads zero", d, 32'h0);
    rd(6, d); check("R11 vector not writable", d, 32'h0);
    rd(0, d); check("R11 high mask untouched", d, 32'h0);
    rd(1, d); check("R11 low mask untouched", d, 32'h0);
    rd(4, d); check("R11 high edge untouched", d, 32'h0);
    check("R11 irq still low", {31'b0, irq_req}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_priority();
    t_edge_w1c();
    t_latency();
    t_collision();
    t_level_noclear();
    t_addr();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule